// File: doc/BRIEF.md
# Masked-Service Interrupt Group Aggregator

This block gathers a group of source interrupt lines into a single interrupt output for a downstream controller. Firmware programs which lines may raise the interrupt through an enable register and reads which lines caused it through a status register. Both registers sit on a simple 32-bit register bus. Once a source has been latched into status and service has begun, further sources are queued in an internal pending vector. They are replayed into status when firmware acknowledges everything that is outstanding.

The enable register does two jobs. A write that introduces new enable bits accumulates into an internal enable vector; enable bits are never removed by a write. A write that adds no new bits is read as a mask operation against the last written value. Bits that turn on are unmasked and bits that turn off are masked. While any mask bit is set, new sources go to pending rather than to status. Status is write-one-to-clear. Writing all ones resets status without any replay or change to the output.

Top module: `irq_group_slice`

## Requirements
- R1: After reset the enable register, the status register, the internal enable, mask and pending vectors and `irqOut` are all zero.
- R2: A source event occurs on each rising transition of the OR of `srcLines`. The select vector is `srcLines` AND internal enable, sampled at that clock edge. A zero select changes nothing.
- R3: On an event with mask zero and status zero, status is loaded with select and `irqOut` is high after that clock edge.
- R4: On an event while status is non-zero or any mask bit is set, select is ORed into pending; status and `irqOut` keep their values.
- R5: Writing zero to the enable register (offset 0x0) while the internal enable is zero only stores zero.
- R6: An enable write is ORed into the internal enable vector. If that adds a bit, the written value is stored and mask is untouched.
- R7: An enable write that adds no bit computes change = stored value XOR data. If change AND data is non-zero, the change bits are cleared from mask; otherwise they are set in mask. The data is then stored.
- R8: Writing zero to the status register (offset 0x4) has no effect.
- R9: A non-zero status write clears the written bits. If status stays non-zero, `irqOut` is unchanged.
- R10: A status write of all ones clears status but neither reloads pending nor changes `irqOut`.
- R11: A non-zero, not-all-ones status write that leaves status zero does one of two things. If pending is non-zero, status takes pending, pending clears and `irqOut` stays high. Otherwise `irqOut` goes low.
- R12: Reads return the stored value at offset 0x0 or 0x4 with no side effect. Other offsets read zero and ignore writes.
- R13: When a register write and a source event fall in the same cycle, the write takes effect first and the event sees its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| srcLines | input | NUM_LINES | Source interrupt lines |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | ADDR_W | Byte offset within the group |
| regWrData | input | NUM_LINES | Write data |
| regRdData | output | NUM_LINES | Read data for `regAddr` (combinational) |
| irqOut | output | 1 | Aggregated interrupt output |

## Verification
The bench builds the block with its defaults: 32 lines and a 4-bit offset. At that width the all-ones initialisation value and a full 32-bit enable word are exercised directly. The unmapped offset 0x8 is reachable, which exercises the address decode. Scenarios drive the mask path by rewriting an unchanged enable set with one bit dropped. That proves the mask through the queuing of a later event, and the unmask through the replay that follows. A same-cycle enable write and event covers the ordering rule.

// File: rtl/irq_group_pkg.sv
package irq_group_pkg;
  typedef struct packed {
    logic wrEnable;
    logic wrStatus;
    logic statusInit;
    logic srcEvent;
    logic rdEnable;
    logic rdStatus;
  } grpStrobes_t;
endpackage

// File: rtl/irq_group_ctrl.sv
module irq_group_ctrl
  import irq_group_pkg::*;
#(
  parameter int NUM_LINES  = 32,
  parameter int ADDR_W     = 4,
  parameter int ENABLE_OFS = 0,
  parameter int STATUS_OFS = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_LINES-1:0] srcLines,
  input  logic                 regWrEn,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic [NUM_LINES-1:0] regWrData,
  output grpStrobes_t          strb
);
  localparam logic [ADDR_W-1:0] EN_ADDR = ADDR_W'(ENABLE_OFS);
  localparam logic [ADDR_W-1:0] ST_ADDR = ADDR_W'(STATUS_OFS);

  logic prevAny;
  logic srcAny;
  logic hitEn;
  logic hitSt;

  assign srcAny = |srcLines;
  assign hitEn  = (regAddr == EN_ADDR);
  assign hitSt  = (regAddr == ST_ADDR);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevAny <= 1'b0;
    else       prevAny <= srcAny;
  end

  always_comb begin
    strb.rdEnable   = hitEn;
    strb.rdStatus   = hitSt;
    strb.wrEnable   = regWrEn && hitEn;
    strb.wrStatus   = regWrEn && hitSt && (regWrData != '0);
    strb.statusInit = regWrEn && hitSt && (regWrData == '1);
    strb.srcEvent   = srcAny && !prevAny;
  end

  a_r2_single_event: assert property (@(posedge clk) disable iff (!rstN)
    strb.srcEvent |=> !strb.srcEvent);
endmodule

// File: rtl/irq_group_dp.sv
module irq_group_dp
  import irq_group_pkg::*;
#(
  parameter int NUM_LINES = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  grpStrobes_t          strb,
  input  logic [NUM_LINES-1:0] srcLines,
  input  logic [NUM_LINES-1:0] wrData,
  output logic [NUM_LINES-1:0] rdData,
  output logic                 irqOut
);
  typedef logic [NUM_LINES-1:0] vec_t;

  vec_t enVec, maskVec, enReg, stReg, pendVec;
  vec_t en1, mask1, enR1, st1, pend1, chg, sel;
  logic irqQ, irq1;

  always_comb begin
    en1   = enVec;
    mask1 = maskVec;
    enR1  = enReg;
    st1   = stReg;
    pend1 = pendVec;
    irq1  = irqQ;
    chg   = '0;
    sel   = '0;
    // register write applies first
    if (strb.wrEnable) begin
      if (wrData == '0 && enVec == '0) begin
        enR1 = wrData;
      end else if ((enVec | wrData) != enVec) begin
        en1  = enVec | wrData;
        enR1 = wrData;
      end else begin
        chg = enReg ^ wrData;
        if ((chg & wrData) != '0) mask1 = maskVec & ~chg;
        else                      mask1 = maskVec | chg;
        enR1 = wrData;
      end
    end
    if (strb.wrStatus) begin
      st1 = stReg & ~wrData;
      if (!strb.statusInit && st1 == '0) begin
        if (pendVec != '0) begin
          st1   = pendVec;
          pend1 = '0;
          irq1  = 1'b1;
        end else begin
          irq1 = 1'b0;
        end
      end
    end
    // then the source event sees the updated state
    if (strb.srcEvent) begin
      sel = srcLines & en1;
      if (sel != '0) begin
        if (mask1 != '0 || st1 != '0) begin
          pend1 = pend1 | sel;
        end else begin
          st1  = sel;
          irq1 = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enVec   <= '0;
      maskVec <= '0;
      enReg   <= '0;
      stReg   <= '0;
      pendVec <= '0;
      irqQ    <= 1'b0;
    end else begin
      enVec   <= en1;
      maskVec <= mask1;
      enReg   <= enR1;
      stReg   <= st1;
      pendVec <= pend1;
      irqQ    <= irq1;
    end
  end

  assign irqOut = irqQ;
  assign rdData = strb.rdEnable ? enReg : (strb.rdStatus ? stReg : '0);

  a_r6_enable_sticky: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((enVec & $past(enVec)) == $past(enVec)));
  a_r3_status_enabled_only: assert property (@(posedge clk) disable iff (!rstN)
    (stReg & ~enVec) == '0);
  a_r11_drop_when_empty: assert property (@(posedge clk) disable iff (!rstN)
    $fell(irqQ) |-> (stReg == '0));
  a_r10_init_keeps_irq: assert property (@(posedge clk) disable iff (!rstN)
    (strb.statusInit && !strb.srcEvent) |=> $stable(irqQ));
  a_r4_busy_holds_status: assert property (@(posedge clk) disable iff (!rstN)
    (strb.srcEvent && stReg != '0 && !strb.wrStatus) |=> $stable(stReg));
endmodule

// File: rtl/irq_group_slice.sv
module irq_group_slice
  import irq_group_pkg::*;
#(
  parameter int NUM_LINES = 32,
  parameter int ADDR_W    = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_LINES-1:0] srcLines,
  input  logic                 regWrEn,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic [NUM_LINES-1:0] regWrData,
  output logic [NUM_LINES-1:0] regRdData,
  output logic                 irqOut
);
  grpStrobes_t strb;

  irq_group_ctrl #(
    .NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W), .ENABLE_OFS(0), .STATUS_OFS(4)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .srcLines(srcLines), .regWrEn(regWrEn),
    .regAddr(regAddr), .regWrData(regWrData), .strb(strb)
  );

  irq_group_dp #(.NUM_LINES(NUM_LINES)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .srcLines(srcLines),
    .wrData(regWrData), .rdData(regRdData), .irqOut(irqOut)
  );
endmodule

// File: tb/sim_irq_group_slice.sv
`timescale 1ns/1ps
module sim_irq_group_slice;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] srcLines = '0;
  logic        regWrEn = 1'b0;
  logic [3:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        irqOut;
  int nChecks = 0;
  int nFails  = 0;

  always #2 clk = ~clk;

  irq_group_slice u0 (
    .clk(clk), .rstN(rstN), .srcLines(srcLines), .regWrEn(regWrEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .irqOut(irqOut)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic busRead(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #0.5 d = regRdData;
  endtask

  task automatic pulse(input logic [31:0] v);
    @(negedge clk); srcLines = v;
    @(negedge clk); srcLines = '0;
  endtask

  task automatic expectRegs(input string req, input logic [31:0] en,
                            input logic [31:0] st, input logic irq);
    logic [31:0] d;
    busRead(4'h0, d); check(req, d, en);
    busRead(4'h4, d); check(req, d, st);
    check(req, {31'd0, irqOut}, {31'd0, irq});
  endtask

  task automatic t_reset;
    expectRegs("R1", 32'h0, 32'h0, 1'b0);
  endtask

  task automatic t_zeroEnable;
    busWrite(4'h0, 32'h0);
    pulse(32'h0000_00FF);
    expectRegs("R5/R2", 32'h0, 32'h0, 1'b0);
  endtask

  task automatic t_enableNew;
    busWrite(4'h0, 32'h0000_00F0);
    expectRegs("R6", 32'h0000_00F0, 32'h0, 1'b0);
    pulse(32'h0000_0F30);
    expectRegs("R2/R3", 32'h0000_00F0, 32'h0000_0030, 1'b1);
  endtask

  task automatic t_busyAndClear;
    pulse(32'h0000_0040);
    pulse(32'h0000_0080);
    expectRegs("R4", 32'h0000_00F0, 32'h0000_0030, 1'b1);
    busWrite(4'h4, 32'h0000_0010);
    expectRegs("R9", 32'h0000_00F0, 32'h0000_0020, 1'b1);
    busWrite(4'h4, 32'h0);
    expectRegs("R8", 32'h0000_00F0, 32'h0000_0020, 1'b1);
    busWrite(4'h4, 32'h0000_0020);
    expectRegs("R11 reload", 32'h0000_00F0, 32'h0000_00C0, 1'b1);
    busWrite(4'h4, 32'h0000_00C0);
    expectRegs("R11 drop", 32'h0000_00F0, 32'h0, 1'b0);
  endtask

  task automatic t_init;
    pulse(32'h0000_0010);
    pulse(32'h0000_0020);
    busWrite(4'h4, 32'hFFFF_FFFF);
    expectRegs("R10", 32'h0000_00F0, 32'h0, 1'b1);
    busWrite(4'h4, 32'h0000_0001);
    expectRegs("R10 pending kept", 32'h0000_00F0, 32'h0000_0020, 1'b1);
    busWrite(4'h4, 32'h0000_0020);
    expectRegs("R11", 32'h0000_00F0, 32'h0, 1'b0);
  endtask

  task automatic t_mask;
    busWrite(4'h0, 32'h0000_00F0);
    busWrite(4'h0, 32'h0000_00E0);
    pulse(32'h0000_0020);
    expectRegs("R7 mask", 32'h0000_00E0, 32'h0, 1'b0);
    busWrite(4'h0, 32'h0000_00F0);
    pulse(32'h0000_0040);
    expectRegs("R7 unmask", 32'h0000_00F0, 32'h0000_0040, 1'b1);
    busWrite(4'h4, 32'h0000_0040);
    expectRegs("R7/R11 replay", 32'h0000_00F0, 32'h0000_0020, 1'b1);
    busWrite(4'h4, 32'h0000_0020);
    expectRegs("R11", 32'h0000_00F0, 32'h0, 1'b0);
  endtask

  task automatic t_decode;
    logic [31:0] d;
    busWrite(4'h8, 32'h0000_0005);
    busRead(4'h8, d); check("R12", d, 32'h0);
    expectRegs("R12", 32'h0000_00F0, 32'h0, 1'b0);
  endtask

  task automatic t_sameCycle;
    @(negedge clk);
    regWrEn = 1'b1; regAddr = 4'h0; regWrData = 32'h0000_01F0;
    srcLines = 32'h0000_0100;
    @(negedge clk);
    regWrEn = 1'b0; srcLines = '0;
    expectRegs("R13", 32'h0000_01F0, 32'h0000_0100, 1'b1);
    busWrite(4'h4, 32'h0000_0100);
    expectRegs("R13 clear", 32'h0000_01F0, 32'h0, 1'b0);
  endtask

  initial begin : watchdog
    #400000;
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_zeroEnable();
    t_enableNew();
    t_busyAndClear();
    t_init();
    t_mask();
    t_decode();
    t_sameCycle();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule